// File: doc/BRIEF.md
# General-Purpose Port Register Bank with Alias Addresses

This block is the software-visible register bank of a 16-bit general-purpose port. A simple 16-bit register bus reaches it. The bus has a select, a write enable, a byte address, an access-size code, write data, registered read data and a registered error flag. The bank holds eight registers. Three of them are main registers: pin data, interrupt mask A and interrupt mask B. The other five are configuration registers: direction, polarity, edge select, both-edge select and input enable. All eight drive their contents straight out to a separate pin-sensing block.

Each main register has four bus addresses. One is a plain write. The other three are write-one aliases that clear, set or toggle only the bits where the write data holds a 1. A read at any of the four addresses returns the single underlying value. The pin-sensing block sends per-bit updates of the data register for pins configured as inputs. The bank applies an update only to a bit that is an input (direction 0) and has its input enabled. When a bus write reaches the data register in the same cycle, the write wins on the bits it touches.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, every register output, `bus_rdata` and `bus_err` are zero.
- R2: An access is legal only if it uses size code 01 (16-bit), a byte offset that is a multiple of 4, and a register index (offset/4) from 0 to 16. Index order is data 0..3, mask A 4..7, mask B 8..11, direction 12, polarity 13, edge 14, both 15, input enable 16. For each main register the aliases run plain, clear, set, toggle. A legal plain write replaces the register, and the register output shows the new value in the cycle after the write.
- R3: A legal write to a clear alias (index 1, 5 or 9) clears the register bits where the write data is 1 and leaves the other bits unchanged.
- R4: A legal write to a set alias (index 2, 6 or 10) ORs the write data into the register.
- R5: A legal write to a toggle alias (index 3, 7 or 11) XORs the write data into the register.
- R6: A legal read at any index returns the register value from before that cycle on `bus_rdata` one cycle later. All four aliases of a main register read the same value. A write cycle returns 0 on `bus_rdata`.
- R7: An access with a size code other than 01 (00 byte, 10 word, 11 reserved) raises `bus_err` one cycle later, returns 0 on `bus_rdata` and changes no register.
- R8: An access at an offset that is not a multiple of 4, or at an index above 16, raises `bus_err` one cycle later, returns 0 on `bus_rdata` and changes no register. A legal access leaves `bus_err` low.
- R9: A data bit takes `pin_upd_val` in the next cycle when its `pin_upd_en` bit is 1, its direction bit is 0 and its input-enable bit is 1. Otherwise the update is ignored.
- R10: When a legal bus write to a data alias and a pin update meet in one cycle, the bus result wins on every bit the write touches. A plain write touches all bits; an alias touches the bits where the write data is 1. The remaining bits follow R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset into the bank |
| bus_size | input | 2 | Access size code (01 = 16-bit) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the access |
| bus_err | output | 1 | Illegal access flag, one cycle after the access |
| pin_upd_en | input | 16 | Per-bit update strobe from the pin sensor |
| pin_upd_val | input | 16 | Sensed pin levels |
| data_o | output | 16 | Data register contents |
| mask_a_o | output | 16 | Mask A register contents |
| mask_b_o | output | 16 | Mask B register contents |
| dir_o | output | 16 | Direction register (1 = output) |
| polar_o | output | 16 | Polarity register |
| edge_o | output | 16 | Edge-select register |
| both_o | output | 16 | Both-edge select register |
| inen_o | output | 16 | Input-enable register |

## Verification
Every register drives a port, so a wrong bit from a misdecoded alias, a wrong operator or a dropped write appears on that port one clock after the access. The registered read path shows it again on the next read of any alias. A broken pin-merge gate or priority shows on `data_o` in the cycle after the colliding update. A missed illegal-access case shows either as an absent `bus_err` or as a configuration output that changes when it should not, both one cycle after the access.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  localparam int NUM_REGS   = 17;
  localparam int NUM_GROUPS = 8;
  localparam int ALIAS_REGS = 3;
  localparam logic [1:0] SIZE_HALF = 2'b01;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_TOGGLE = 2'd3
  } alias_op_e;

  typedef enum logic [2:0] {
    GRP_DATA  = 3'd0,
    GRP_MASKA = 3'd1,
    GRP_MASKB = 3'd2,
    GRP_DIR   = 3'd3,
    GRP_POLAR = 3'd4,
    GRP_EDGE  = 3'd5,
    GRP_BOTH  = 3'd6,
    GRP_INEN  = 3'd7
  } reg_grp_e;

  typedef struct packed {
    logic      legal;
    logic      bad;
    logic      wr;
    reg_grp_e  grp;
    alias_op_e op;
  } acc_dec_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regbank_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output acc_dec_t          dec
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int ALIAS_SPAN = ALIAS_REGS * 4;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             in_map;
  logic             size_ok;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign in_map  = (idx < IDX_W'(NUM_REGS));
  assign size_ok = (size == SIZE_HALF);

  always_comb begin
    dec       = '0;
    dec.legal = sel & aligned & in_map & size_ok;
    dec.bad   = sel & ~(aligned & in_map & size_ok);
    dec.wr    = we;
    if (idx < IDX_W'(ALIAS_SPAN)) begin
      dec.grp = reg_grp_e'({1'b0, idx[3:2]});
      dec.op  = alias_op_e'(idx[1:0]);
    end else begin
      dec.grp = reg_grp_e'(3'(idx - IDX_W'(ALIAS_SPAN - ALIAS_REGS)));
      dec.op  = OP_WRITE;
    end
  end

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_regbank_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  alias_op_e     op,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_en,
  input  logic [DW-1:0] pin_val,
  output logic [DW-1:0] q
);

  logic [DW-1:0] bus_res;
  logic [DW-1:0] touch;
  logic [DW-1:0] pin_base;
  logic [DW-1:0] q_nxt;
  logic          q_en;

  always_comb begin
    bus_res = q;
    touch   = '0;
    if (wr_en) begin
      unique case (op)
        OP_WRITE:  begin bus_res = wdata;      touch = '1;    end
        OP_CLEAR:  begin bus_res = q & ~wdata; touch = wdata; end
        OP_SET:    begin bus_res = q | wdata;  touch = wdata; end
        OP_TOGGLE: begin bus_res = q ^ wdata;  touch = wdata; end
        default:   begin bus_res = q;          touch = '0;    end
      endcase
    end
    pin_base = (q & ~pin_en) | (pin_val & pin_en);
    q_nxt    = (bus_res & touch) | (pin_base & ~touch);
    q_en     = wr_en | (|pin_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (q_en) q <= q_nxt;
  end

endmodule

// File: rtl/gpio_plain_reg.sv
module gpio_plain_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= wdata;
  end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_regbank_pkg::*;
#(
  parameter int DW = 16
) (
  input  acc_dec_t                      dec,
  input  logic [NUM_GROUPS-1:0][DW-1:0] bank,
  output logic [DW-1:0]                 rd_nxt,
  output logic                          err_nxt
);

  always_comb begin
    rd_nxt  = '0;
    err_nxt = dec.bad;
    if (dec.legal && !dec.wr) rd_nxt = bank[dec.grp];
  end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [DATA_W-1:0] pin_upd_en,
  input  logic [DATA_W-1:0] pin_upd_val,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] mask_a_o,
  output logic [DATA_W-1:0] mask_b_o,
  output logic [DATA_W-1:0] dir_o,
  output logic [DATA_W-1:0] polar_o,
  output logic [DATA_W-1:0] edge_o,
  output logic [DATA_W-1:0] both_o,
  output logic [DATA_W-1:0] inen_o
);

  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  acc_dec_t dec;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel  (bus_sel),
    .we   (bus_we),
    .addr (bus_addr),
    .size (bus_size),
    .dec  (dec)
  );

  logic [NUM_GROUPS-1:0][DATA_W-1:0] bank;
  logic [NUM_GROUPS-1:0]             grp_wr;
  logic [DATA_W-1:0]                 pin_eff;

  always_comb begin
    grp_wr = '0;
    if (dec.legal && dec.wr) grp_wr[dec.grp] = 1'b1;
  end

  assign pin_eff = pin_upd_en & ~bank[GRP_DIR] & bank[GRP_INEN];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_reg
    if (g < ALIAS_REGS) begin : g_alias
      logic [DATA_W-1:0] en_g;
      logic [DATA_W-1:0] val_g;
      if (g == GRP_DATA) begin : g_pin
        assign en_g  = pin_eff;
        assign val_g = pin_upd_val;
      end else begin : g_nopin
        assign en_g  = '0;
        assign val_g = '0;
      end
      gpio_alias_reg #(.DW(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .wr_en   (grp_wr[g]),
        .op      (dec.op),
        .wdata   (bus_wdata),
        .pin_en  (en_g),
        .pin_val (val_g),
        .q       (bank[g])
      );
    end else begin : g_plain
      gpio_plain_reg #(.DW(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_core_n),
        .wr_en (grp_wr[g]),
        .wdata (bus_wdata),
        .q     (bank[g])
      );
    end
  end

  logic [DATA_W-1:0] rd_nxt;
  logic              err_nxt;

  gpio_read_mux #(.DW(DATA_W)) u_rmux (
    .dec     (dec),
    .bank    (bank),
    .rd_nxt  (rd_nxt),
    .err_nxt (err_nxt)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_nxt;
      bus_err   <= err_nxt;
    end
  end

  assign data_o   = bank[GRP_DATA];
  assign mask_a_o = bank[GRP_MASKA];
  assign mask_b_o = bank[GRP_MASKB];
  assign dir_o    = bank[GRP_DIR];
  assign polar_o  = bank[GRP_POLAR];
  assign edge_o   = bank[GRP_EDGE];
  assign both_o   = bank[GRP_BOTH];
  assign inen_o   = bank[GRP_INEN];

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_err,
  input logic [DW-1:0] pin_upd_en,
  input logic [DW-1:0] pin_upd_val,
  input logic [DW-1:0] data_o,
  input logic [DW-1:0] mask_a_o,
  input logic [DW-1:0] mask_b_o,
  input logic [DW-1:0] dir_o,
  input logic [DW-1:0] polar_o,
  input logic [DW-1:0] edge_o,
  input logic [DW-1:0] both_o,
  input logic [DW-1:0] inen_o
);

  logic ok;
  logic okw;
  logic [DW-1:0] eff;

  assign ok  = bus_sel && (bus_size == 2'b01) && (bus_addr[1:0] == 2'b00)
               && (bus_addr[AW-1:2] < (AW-2)'(17));
  assign okw = ok && bus_we;
  assign eff = pin_upd_en & ~dir_o & inen_o;

  assert_legal_no_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> !bus_err);

  assert_plain_data_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (okw && bus_addr == AW'('h00)) |=> data_o == $past(bus_wdata));

  assert_clear_mask_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (okw && bus_addr == AW'('h14)) |=> mask_a_o == ($past(mask_a_o) & ~$past(bus_wdata)));

  assert_set_mask_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (okw && bus_addr == AW'('h28)) |=> mask_b_o == ($past(mask_b_o) | $past(bus_wdata)));

  assert_toggle_mask_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (okw && bus_addr == AW'('h1C)) |=> mask_a_o == ($past(mask_a_o) ^ $past(bus_wdata)));

  assert_bad_flags_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !ok) |=> (bus_err && bus_rdata == '0));

  assert_bad_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !ok) |=> ($stable(mask_a_o) && $stable(mask_b_o) && $stable(dir_o)
      && $stable(polar_o) && $stable(edge_o) && $stable(both_o) && $stable(inen_o)));

  assert_pin_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !okw |=> data_o == (($past(data_o) & ~$past(eff)) | ($past(pin_upd_val) & $past(eff))));

endmodule

bind gpio_regbank gpio_regbank_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (.*);

// File: tb/tb_gpio_regbank.sv
`timescale 1ns/1ps
module tb_gpio_regbank;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [15:0] pin_upd_en;
  logic [15:0] pin_upd_val;
  logic [15:0] data_o, mask_a_o, mask_b_o, dir_o, polar_o, edge_o, both_o, inen_o;

  gpio_regbank dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] m [8];

  typedef struct {
    logic [15:0] rd;
    logic        err;
    logic [15:0] outs [8];
    string       req;
  } exp_t;
  exp_t sb [$];

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 0; bus_we = 0; pin_upd_en = '0; pin_upd_val = '0;
  endtask

  task automatic access(input bit we, input logic [6:0] addr, input logic [1:0] size,
                        input logic [15:0] wd, input logic [15:0] pen, input logic [15:0] pval,
                        input string req);
    exp_t e;
    int idx, grp, op;
    bit legal;
    logic [15:0] eff, merged, res, touch;
    idx   = int'(addr[6:2]);
    legal = (size == 2'b01) && (addr[1:0] == 2'b00) && (idx <= 16);
    if (idx < 12) begin grp = idx / 4; op = idx % 4; end
    else begin grp = idx - 9; op = 0; end
    e.err = !legal;
    e.rd  = (legal && !we) ? m[grp] : 16'h0;
    e.req = req;
    eff    = pen & ~m[3] & m[7];
    merged = (m[0] & ~eff) | (pval & eff);
    if (legal && we) begin
      res = m[grp]; touch = 16'hFFFF;
      case (op)
        0: res = wd;
        1: begin res = m[grp] & ~wd; touch = wd; end
        2: begin res = m[grp] | wd;  touch = wd; end
        default: begin res = m[grp] ^ wd; touch = wd; end
      endcase
      if (grp == 0) m[0] = (res & touch) | (merged & ~touch);
      else begin m[grp] = res; m[0] = merged; end
    end else m[0] = merged;
    for (int k = 0; k < 8; k++) e.outs[k] = m[k];
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = addr; bus_size = size; bus_wdata = wd;
    pin_upd_en = pen; pin_upd_val = pval;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d, input string req);
    access(1, a, 2'b01, d, 16'h0, 16'h0, req);
  endtask
  task automatic rd(input logic [6:0] a, input string req);
    access(0, a, 2'b01, 16'h0, 16'h0, 16'h0, req);
  endtask

  initial begin : monitor
    exp_t e;
    logic [15:0] act [8];
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        act = '{data_o, mask_a_o, mask_b_o, dir_o, polar_o, edge_o, both_o, inen_o};
        chk(e.req, "bus_rdata", bus_rdata, e.rd);
        chk(e.req, "bus_err", {15'h0, bus_err}, {15'h0, e.err});
        for (int k = 0; k < 8; k++) chk(e.req, $sformatf("reg%0d", k), act[k], e.outs[k]);
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    for (int k = 0; k < 8; k++) m[k] = '0;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_size = 2'b01;
    bus_wdata = '0; pin_upd_en = '0; pin_upd_val = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "data_o", data_o, 16'h0);
    chk("R1", "mask_a_o", mask_a_o, 16'h0);
    chk("R1", "dir_o", dir_o, 16'h0);
    chk("R1", "inen_o", inen_o, 16'h0);
    chk("R1", "bus_rdata", bus_rdata, 16'h0);
    chk("R1", "bus_err", {15'h0, bus_err}, 16'h0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    rd(7'h00, "R1");
    rd(7'h40, "R1");

    // R2: plain writes to every register, read back (R6)
    wr(7'h00, 16'hA5C3, "R2");
    wr(7'h10, 16'h1234, "R2");
    wr(7'h20, 16'hF00F, "R2");
    wr(7'h30, 16'h0F0F, "R2");
    wr(7'h34, 16'h5555, "R2");
    wr(7'h38, 16'hAAAA, "R2");
    wr(7'h3C, 16'h8001, "R2");
    wr(7'h40, 16'hFFFF, "R2");
    for (int a = 0; a < 17; a++) rd(7'(a * 4), "R6");

    // R3 / R4 / R5 on each aliased register
    wr(7'h04, 16'h00FF, "R3");
    wr(7'h14, 16'h0230, "R3");
    wr(7'h24, 16'hF000, "R3");
    wr(7'h08, 16'h1100, "R4");
    wr(7'h18, 16'h8008, "R4");
    wr(7'h28, 16'h0660, "R4");
    wr(7'h0C, 16'hFFFF, "R5");
    wr(7'h1C, 16'h0F0F, "R5");
    wr(7'h2C, 16'h3C3C, "R5");
    wr(7'h14, 16'h0000, "R3");
    wr(7'h28, 16'h0000, "R4");
    for (int a = 0; a < 12; a++) rd(7'(a * 4), "R6");

    // R7: bad sizes, reads and writes
    access(1, 7'h10, 2'b00, 16'hDEAD, 16'h0, 16'h0, "R7");
    access(1, 7'h30, 2'b10, 16'hBEEF, 16'h0, 16'h0, "R7");
    access(0, 7'h40, 2'b11, 16'h0, 16'h0, 16'h0, "R7");
    access(1, 7'h00, 2'b00, 16'h0000, 16'h0, 16'h0, "R7");

    // R8: out of map and misaligned
    access(1, 7'h44, 2'b01, 16'h1111, 16'h0, 16'h0, "R8");
    access(0, 7'h7C, 2'b01, 16'h0, 16'h0, 16'h0, "R8");
    access(1, 7'h12, 2'b01, 16'h2222, 16'h0, 16'h0, "R8");
    access(0, 7'h01, 2'b01, 16'h0, 16'h0, 16'h0, "R8");
    rd(7'h10, "R8");

    // R9: pin updates gated by direction and input enable
    wr(7'h30, 16'h00F0, "R9");
    wr(7'h40, 16'hFF0F, "R9");
    access(0, 7'h34, 2'b01, 16'h0, 16'hFFFF, 16'h1234, "R9");
    access(0, 7'h00, 2'b01, 16'h0, 16'h0F0F, 16'hFFFF, "R9");
    access(0, 7'h00, 2'b01, 16'h0, 16'hF0F0, 16'h0000, "R9");
    rd(7'h0C, "R9");
    idle();
    pin_upd_en = 16'hFFFF; pin_upd_val = 16'h5A5A;
    @(posedge clk); #1;
    m[0] = (m[0] & ~(16'hFFFF & ~m[3] & m[7])) | (16'h5A5A & ~m[3] & m[7]);
    chk("R9", "data_o pin-only cycle", data_o, m[0]);

    // R10: bus write and pin update collide on data
    access(1, 7'h08, 2'b01, 16'h000F, 16'hFFFF, 16'h0000, "R10");
    access(1, 7'h04, 2'b01, 16'h0300, 16'hFFFF, 16'hFFFF, "R10");
    access(1, 7'h0C, 2'b01, 16'h00FF, 16'hFFFF, 16'hAAAA, "R10");
    access(1, 7'h00, 2'b01, 16'h1357, 16'hFFFF, 16'hFFFF, "R10");
    access(1, 7'h1C, 2'b01, 16'h0101, 16'hFFFF, 16'h0000, "R10");
    rd(7'h08, "R10");

    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R6", "scoreboard empty", 16'(sb.size()), 16'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule